// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer

This block is the hardwired control sequencer of a small accumulator machine that uses 16-bit instruction words and 12-bit addresses. A 4-bit step counter is decoded into sixteen one-hot timing signals. Each instruction runs through a fixed series of steps. In the first three steps the block loads the address register from the program counter, then reads the instruction word into the instruction register while the program counter is incremented, then decodes the 3-bit opcode into eight one-hot lines, loads the 12-bit address field and captures the indirect bit. The fourth step either resolves an indirect address with a second memory read or starts a register-class or I/O-class instruction, and those two classes finish there.

Memory-class instructions run from the fifth step onward under an execute strobe. Each opcode finishes at its own step. Two control transfers are carried out inside the block: an unconditional jump and a jump that first saves the return address. At the end of any instruction the interrupt request is sampled. When it is set, the block replaces the next fetch with a three-step interrupt cycle. That cycle stores the program counter at address 0 and resumes execution at address 1.

The sequencer has two named cycle states. CYC_INSTR covers normal fetch and execution, and CYC_INTR is the interrupt cycle. The transition CYC_INSTR to CYC_INTR happens on the closing step of an instruction when `irq_req` is high. The transition CYC_INTR to CYC_INSTR happens at the end of step T2 of the interrupt cycle. Every other closing step keeps the state in CYC_INSTR.

Top module: `instr_sequencer`

## Requirements
- R1: While `rst` is high, `t_sig` is 16'h0001 (step T0), `pc_q` and `ar_q` are 0 and `intr_cyc` is 0.
- R2: Exactly one bit of `t_sig` is high. When the counter is not cleared, the high bit moves up by one position per clock.
- R3: At T0 of an instruction, `ar_q` takes the value of `pc_q` at the next edge.
- R4: At T1, `mem_rd` is high, the instruction register loads `mem_rdata`, and `pc_q` increments by one at the next edge.
- R5: At T2, `d_sig` is one-hot on opcode bits [14:12] of the instruction, `ar_q` loads bits [11:0] and the indirect flag takes bit 15.
- R6: At T3 with opcode other than 7: if the indirect bit is 1, then `mem_rd` is high and `ar_q` loads `mem_rdata[11:0]`. If the indirect bit is 0, no memory strobe or execute strobe is raised.
- R7: At T3 with opcode 7, `exec_reg` (indirect bit 0) or `exec_io` (indirect bit 1) is high for that step, `sc_clr` is high, and the following step is T0.
- R8: For opcodes 0 to 6, `exec_mem` is high from T4 up to the closing step. The closing step is T4 for opcodes 3 and 4, T5 for opcodes 0, 1, 2 and 5, and T6 for opcode 6. `mem_rd` is high at T4 for opcodes 0, 1, 2 and 6.
- R9: Opcode 4 (jump) loads `pc_q` from `ar_q` at T4.
- R10: Opcode 5 (call) writes the zero-extended `pc_q` to memory at `ar_q` at T4 and increments `ar_q`, then loads `pc_q` from `ar_q` at T5.
- R11: `irq_req` is sampled only on an instruction's closing step. If it is high there, the next step is T0 with `intr_cyc` high and no fetch strobes. If it is high on other steps, there is no effect.
- R12: In the interrupt cycle, T0 clears `ar_q`. T1 writes the old `pc_q` to address 0 and clears `pc_q`. T2 increments `pc_q`, and the next step is a normal T0 with `pc_q` equal to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for every register |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 16 | Memory word read at `mem_addr` |
| irq_req | input | 1 | Interrupt request, sampled at instruction end |
| mem_addr | output | 12 | Memory address, equal to the address register |
| mem_wdata | output | 16 | Write data, zero-extended program counter |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| pc_q | output | 12 | Program counter |
| ar_q | output | 12 | Address register |
| ir_q | output | 16 | Instruction register |
| t_sig | output | 16 | One-hot timing signals T0..T15 |
| d_sig | output | 8 | One-hot opcode lines D0..D7 |
| ind_q | output | 1 | Captured indirect bit |
| ar_ld | output | 1 | Address register parallel load |
| ar_inr | output | 1 | Address register increment |
| ar_clr | output | 1 | Address register clear |
| pc_ld | output | 1 | Program counter load from address register |
| pc_inr | output | 1 | Program counter increment |
| pc_clr | output | 1 | Program counter clear |
| ir_ld | output | 1 | Instruction register load |
| sc_clr | output | 1 | Step counter clear (instruction end) |
| exec_reg | output | 1 | Register-class execute strobe |
| exec_io | output | 1 | I/O-class execute strobe |
| exec_mem | output | 1 | Memory-class execute strobe |
| intr_cyc | output | 1 | Interrupt cycle in progress |

## Verification
A short program is run through the block. It contains register-class and I/O-class words, a direct jump, an indirect call, and memory-class words of opcodes 3, 6 and 2. Together these cover every closing step (T3, T4, T5, T6) and both settings of the indirect bit. The program counter and address register are compared step by step, which separates direct from indirect address resolution and shows whether each transfer happens at the right step. The interrupt request is raised once on a non-closing step, where it must have no effect, and once on a closing step, where it must start the interrupt cycle. Memory contents written by the call and by the interrupt cycle are read back afterwards.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 12;
    localparam int OP_W    = 3;
    localparam int STEP_W  = 4;

    typedef enum logic {
        CYC_INSTR = 1'b0,
        CYC_INTR  = 1'b1
    } cyc_e;

    // closing step of a memory-class opcode
    function automatic logic [STEP_W-1:0] close_step(input logic [OP_W-1:0] op);
        logic [STEP_W-1:0] s;
        unique case (op)
            3'd3, 3'd4: s = STEP_W'(4);
            3'd6:       s = STEP_W'(6);
            default:    s = STEP_W'(5);
        endcase
        return s;
    endfunction
endpackage

// File: rtl/step_decoder.sv
module step_decoder #(
    parameter int SW = 4,
    localparam int NS = 1 << SW
) (
    input  logic [SW-1:0] step,
    output logic [NS-1:0] t_onehot
);
    for (genvar i = 0; i < NS; i++) begin : g_t
        assign t_onehot[i] = (step == SW'(i));
    end
endmodule

// File: rtl/op_decoder.sv
module op_decoder #(
    parameter int OW = 3,
    localparam int NO = 1 << OW
) (
    input  logic [OW-1:0] op,
    output logic [NO-1:0] d_onehot
);
    for (genvar i = 0; i < NO; i++) begin : g_d
        assign d_onehot[i] = (op == OW'(i));
    end
endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
    import seq_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    localparam int OW = OP_W,
    localparam int SW = STEP_W,
    localparam int NS = 1 << SW,
    localparam int NO = 1 << OW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] mem_rdata,
    input  logic          irq_req,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] pc_q,
    output logic [AW-1:0] ar_q,
    output logic [DW-1:0] ir_q,
    output logic [NS-1:0] t_sig,
    output logic [NO-1:0] d_sig,
    output logic          ind_q,
    output logic          ar_ld,
    output logic          ar_inr,
    output logic          ar_clr,
    output logic          pc_ld,
    output logic          pc_inr,
    output logic          pc_clr,
    output logic          ir_ld,
    output logic          sc_clr,
    output logic          exec_reg,
    output logic          exec_io,
    output logic          exec_mem,
    output logic          intr_cyc
);
    cyc_e          cyc_q, cyc_d;
    logic [SW-1:0] sc_q;
    logic [OW-1:0] opcode;
    logic          ld_from_pc, ld_from_ir, ld_from_mem, mem_done;

    assign opcode    = ir_q[DW-2 -: OW];
    assign mem_addr  = ar_q;
    assign mem_wdata = {{(DW-AW){1'b0}}, pc_q};
    assign intr_cyc  = (cyc_q == CYC_INTR);

    step_decoder #(.SW(SW)) u_step (.step(sc_q), .t_onehot(t_sig));
    op_decoder   #(.OW(OW)) u_op   (.op(opcode), .d_onehot(d_sig));

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= CYC_INSTR;
            sc_q  <= '0;
            pc_q  <= '0;
            ar_q  <= '0;
            ir_q  <= '0;
            ind_q <= 1'b0;
        end else begin
            cyc_q <= cyc_d;
            sc_q  <= sc_clr ? '0 : sc_q + 1'b1;
            if (ar_clr)           ar_q <= '0;
            else if (ld_from_pc)  ar_q <= pc_q;
            else if (ld_from_ir)  ar_q <= ir_q[AW-1:0];
            else if (ld_from_mem) ar_q <= mem_rdata[AW-1:0];
            else if (ar_inr)      ar_q <= ar_q + 1'b1;
            if (pc_clr)      pc_q <= '0;
            else if (pc_ld)  pc_q <= ar_q;
            else if (pc_inr) pc_q <= pc_q + 1'b1;
            if (ir_ld)      ir_q  <= mem_rdata;
            if (ld_from_ir) ind_q <= ir_q[DW-1];
        end
    end

    // control strobes and next state
    always_comb begin
        ld_from_pc  = 1'b0;
        ld_from_ir  = 1'b0;
        ld_from_mem = 1'b0;
        ar_inr      = 1'b0;
        ar_clr      = 1'b0;
        pc_ld       = 1'b0;
        pc_inr      = 1'b0;
        pc_clr      = 1'b0;
        ir_ld       = 1'b0;
        mem_rd      = 1'b0;
        mem_wr      = 1'b0;
        exec_reg    = 1'b0;
        exec_io     = 1'b0;
        exec_mem    = 1'b0;
        mem_done    = 1'b0;
        sc_clr      = 1'b0;
        cyc_d       = cyc_q;
        unique case (cyc_q)
            CYC_INSTR: begin
                ld_from_pc  = t_sig[0];
                ir_ld       = t_sig[1];
                pc_inr      = t_sig[1];
                ld_from_ir  = t_sig[2];
                ld_from_mem = t_sig[3] && !d_sig[7] && ind_q;
                exec_reg    = t_sig[3] && d_sig[7] && !ind_q;
                exec_io     = t_sig[3] && d_sig[7] && ind_q;
                exec_mem    = !d_sig[7] && (sc_q >= SW'(4));
                mem_done    = exec_mem && (sc_q == close_step(opcode));
                mem_rd      = t_sig[1] || ld_from_mem ||
                              (t_sig[4] && (d_sig[0] || d_sig[1] || d_sig[2] || d_sig[6]));
                mem_wr      = t_sig[4] && d_sig[5];
                ar_inr      = t_sig[4] && d_sig[5];
                pc_ld       = (t_sig[4] && d_sig[4]) || (t_sig[5] && d_sig[5]);
                sc_clr      = exec_reg || exec_io || mem_done;
                if (sc_clr && irq_req) cyc_d = CYC_INTR;
            end
            CYC_INTR: begin
                ar_clr = t_sig[0];
                mem_wr = t_sig[1];
                pc_clr = t_sig[1];
                pc_inr = t_sig[2];
                sc_clr = t_sig[2];
                if (t_sig[2]) cyc_d = CYC_INSTR;
            end
            default: cyc_d = CYC_INSTR;
        endcase
    end

    assign ar_ld = ld_from_pc || ld_from_ir || ld_from_mem;

    // checks against the guarded logic
    logic armed_q;
    always_ff @(posedge clk) armed_q <= !rst;

    assert_step_advance_R2: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !$past(sc_clr) |-> (t_sig == ($past(t_sig) << 1)));
    assert_step_restart_R7: assert property (@(posedge clk) disable iff (rst)
        sc_clr |=> t_sig[0]);
    assert_fetch_incr_R4: assert property (@(posedge clk) disable iff (rst)
        (!intr_cyc && t_sig[1]) |=> (pc_q == $past(pc_q) + 1'b1));
    assert_close_bound_R8: assert property (@(posedge clk) disable iff (rst)
        exec_mem |-> (sc_q <= close_step(opcode)));
    assert_intr_entry_R11: assert property (@(posedge clk) disable iff (rst)
        (!intr_cyc && sc_clr && irq_req) |=> (intr_cyc && t_sig[0]));
    assert_intr_vector_R12: assert property (@(posedge clk) disable iff (rst)
        (intr_cyc && t_sig[2]) |=> (!intr_cyc && pc_q == AW'(1)));
endmodule

// File: tb/instr_sequencer_tb_top.sv
`timescale 1ns/1ps
module instr_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 1'b0;
    logic [15:0] mem_rdata, mem_wdata, ir_q;
    logic [11:0] mem_addr, pc_q, ar_q;
    logic        mem_rd, mem_wr, ind_q, ar_ld, ar_inr, ar_clr, pc_ld, pc_inr, pc_clr;
    logic        ir_ld, sc_clr, exec_reg, exec_io, exec_mem, intr_cyc;
    logic [15:0] t_sig;
    logic [7:0]  d_sig;

    logic [15:0] mem [256];
    int n_cmp = 0, n_bad = 0;
    bit go = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    instr_sequencer dut_i (
        .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .irq_req(irq_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .pc_q(pc_q), .ar_q(ar_q), .ir_q(ir_q), .t_sig(t_sig), .d_sig(d_sig),
        .ind_q(ind_q), .ar_ld(ar_ld), .ar_inr(ar_inr), .ar_clr(ar_clr),
        .pc_ld(pc_ld), .pc_inr(pc_inr), .pc_clr(pc_clr), .ir_ld(ir_ld),
        .sc_clr(sc_clr), .exec_reg(exec_reg), .exec_io(exec_io),
        .exec_mem(exec_mem), .intr_cyc(intr_cyc)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

    // flag bits: {rd, wr, exec_reg, exec_io, exec_mem, intr}
    localparam logic [5:0] F_RD = 6'b100000, F_WR = 6'b010000, F_REG = 6'b001000,
                           F_IO = 6'b000100, F_MEM = 6'b000010, F_INT = 6'b000001;

    typedef struct {
        string       req;
        int          step;
        logic [11:0] pc;
        logic [11:0] ar;
        logic [5:0]  flags;
        int          d;
        bit          irq;
    } item_t;
    item_t q[$];

    task automatic push(string req, int step, logic [11:0] pc, logic [11:0] ar,
                        logic [5:0] flags, int d, bit irq);
        item_t it;
        it.req = req; it.step = step; it.pc = pc; it.ar = ar;
        it.flags = flags; it.d = d; it.irq = irq;
        q.push_back(it);
    endtask

    task automatic fetch(logic [11:0] pc, logic [11:0] ar_prev, logic [15:0] word);
        push("R3", 0, pc, ar_prev, 6'b0, -1, 1'b0);
        push("R4", 1, pc, pc, F_RD, -1, 1'b0);
        push("R5", 2, pc + 12'd1, pc, 6'b0, int'(word[14:12]), 1'b0);
    endtask

    task automatic check(string req, bit ok, string act, string exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    // monitor: pops one expected step per cycle and compares
    initial begin
        wait (go);
        while (q.size() > 0) begin
            item_t it;
            logic [5:0] f;
            bit ok;
            @(negedge clk);
            it = q.pop_front();
            f = {mem_rd, mem_wr, exec_reg, exec_io, exec_mem, intr_cyc};
            ok = (t_sig == (16'h1 << it.step)) && (pc_q == it.pc) && (ar_q == it.ar) &&
                 (f == it.flags) && (it.d < 0 || d_sig == (8'h1 << it.d));
            check(it.req, ok,
                  $sformatf("t=%h pc=%h ar=%h f=%b d=%h", t_sig, pc_q, ar_q, f, d_sig),
                  $sformatf("T%0d pc=%h ar=%h f=%b d=%0d", it.step, it.pc, it.ar, it.flags, it.d));
            irq_req = it.irq;
        end
        finished = 1'b1;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[8'h00] = 16'h7800;   // register class
        mem[8'h01] = 16'hF123;   // I/O class
        mem[8'h02] = 16'h4010;   // direct jump to 0x010
        mem[8'h10] = 16'hD020;   // indirect call via 0x020
        mem[8'h20] = 16'h0030;
        mem[8'h31] = 16'h3050;   // opcode 3, closes at T4
        mem[8'h32] = 16'h6060;   // opcode 6, closes at T6
        mem[8'h33] = 16'h2040;   // opcode 2, closes at T5

        fetch(12'h000, 12'h000, 16'h7800);
        push("R7", 3, 12'h001, 12'h800, F_REG, 7, 1'b0);
        fetch(12'h001, 12'h800, 16'hF123);
        push("R7", 3, 12'h002, 12'h123, F_IO, 7, 1'b0);
        fetch(12'h002, 12'h123, 16'h4010);
        push("R6", 3, 12'h003, 12'h010, 6'b0, 4, 1'b0);
        push("R9", 4, 12'h003, 12'h010, F_MEM, 4, 1'b0);
        fetch(12'h010, 12'h010, 16'hD020);
        push("R6", 3, 12'h011, 12'h020, F_RD, 5, 1'b0);
        push("R10", 4, 12'h011, 12'h030, F_MEM | F_WR, 5, 1'b0);
        push("R10", 5, 12'h011, 12'h031, F_MEM, 5, 1'b0);
        fetch(12'h031, 12'h031, 16'h3050);
        push("R6", 3, 12'h032, 12'h050, 6'b0, 3, 1'b0);
        push("R8", 4, 12'h032, 12'h050, F_MEM, 3, 1'b0);
        fetch(12'h032, 12'h050, 16'h6060);
        push("R8", 3, 12'h033, 12'h060, 6'b0, 6, 1'b0);
        push("R11", 4, 12'h033, 12'h060, F_MEM | F_RD, 6, 1'b1);
        push("R11", 5, 12'h033, 12'h060, F_MEM, 6, 1'b0);
        push("R8", 6, 12'h033, 12'h060, F_MEM, 6, 1'b0);
        fetch(12'h033, 12'h060, 16'h2040);
        push("R8", 3, 12'h034, 12'h040, 6'b0, 2, 1'b0);
        push("R8", 4, 12'h034, 12'h040, F_MEM | F_RD, 2, 1'b0);
        push("R11", 5, 12'h034, 12'h040, F_MEM, 2, 1'b1);
        push("R11", 0, 12'h034, 12'h040, F_INT, -1, 1'b0);
        push("R12", 1, 12'h034, 12'h000, F_INT | F_WR, -1, 1'b0);
        push("R12", 2, 12'h000, 12'h000, F_INT, -1, 1'b0);
        fetch(12'h001, 12'h000, 16'hF123);
        push("R12", 3, 12'h002, 12'h123, F_IO, 7, 1'b0);

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", t_sig == 16'h0001 && pc_q == 12'h0 && ar_q == 12'h0 && !intr_cyc,
              $sformatf("t=%h pc=%h ar=%h i=%b", t_sig, pc_q, ar_q, intr_cyc),
              "t=0001 pc=000 ar=000 i=0");
        @(posedge clk);
        #1 rst = 1'b0;
        go = 1'b1;
        wait (finished);
        @(negedge clk);
        check("R10", mem[8'h30] == 16'h0011, $sformatf("%h", mem[8'h30]), "0011");
        check("R12", mem[8'h00] == 16'h0034, $sformatf("%h", mem[8'h00]), "0034");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule